// File: doc/BRIEF.md
# Multi-Pin Wake Detector

This block decides when a suspended device should wake. It watches a bank of general-purpose wake pins (eight by default) and the main suspend pin. It also takes the suspended status reported by the suspend sequencer. When the wake condition is met, it issues a single-cycle wake trigger to the sequencer.

There are two wake modes, chosen by `multi_en`:

- **Multi-pin mode on.** The suspend pin must first be released low. After that, a fresh rising edge on any pin enabled in `pin_mask` produces the trigger.
- **Multi-pin mode off.** Releasing the suspend pin is enough to wake the device.

Every pin and the suspend pin pass through a two-flop synchroniser before any decision is made. Detection is armed once per suspend episode and disarms after it fires. A status flag reports a configuration that could never wake through the pins: multi-pin mode on with an all-zero mask.

Top module: `multipin_wake_detector`

## Requirements
- R1: Each wake pin has its own synchroniser and rising-edge detector. A pin driven high while armed produces the trigger on the third rising clock edge after the change.
- R2: Bit i of `pin_mask` enables pin i. With mask 0x0F only pins 3..0 can wake the device, and with mask 0xFF all eight can.
- R3: With `multi_en`=1, a pin edge that occurs while the suspend pin is still high is ignored. Only an edge after the suspend pin has been seen low wakes the device.
- R4: With `multi_en`=0 and `suspended`=1, the suspend pin falling produces the trigger on the third rising clock edge after the change, regardless of the pins.
- R5: With `multi_en`=1, the suspend pin falling alone produces no trigger.
- R6: A pin whose mask bit is 0 never produces a trigger, even when it toggles.
- R7: A pin that is already high when detection arms does not wake the device until it falls and rises again.
- R8: `wake_pulse` is high for exactly one cycle. After it fires, no further trigger occurs until `suspended` falls and a new suspend episode begins.
- R9: While `suspended`=0, no trigger is produced.
- R10: `mask_empty` is 1 one cycle after `multi_en`=1 with `pin_mask`=0, and 0 one cycle after any other combination.
- R11: Synchronous active-high reset clears `wake_pulse` and `mask_empty` to 0 and returns detection to the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pins | input | 8 | Asynchronous wake pin levels |
| pin_mask | input | 8 | Per-pin wake enable, bit i for pin i |
| multi_en | input | 1 | Multi-pin wake mode enable |
| suspend_pin | input | 1 | Asynchronous suspend pin level (high = suspend requested) |
| suspended | input | 1 | Suspend status from the sequencer, synchronous to clk |
| wake_pulse | output | 1 | Single-cycle wake trigger |
| mask_empty | output | 1 | Multi-pin mode on with no pin enabled |

## Verification
The trigger is due on the third rising edge after a pin or suspend-pin change: two synchroniser flops, then the registered trigger. The bench therefore drives inputs on falling edges and samples at the falling edge after that third edge, and also checks that the output is still low one edge earlier. The status flag is registered once, so it is sampled one falling edge after its inputs change. Table-driven episodes do not pin down timing; instead they count trigger cycles over windows that are long enough to cover the full latency. A count of exactly one shows both that the wake occurred and that the pulse was single-cycle.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int WK_DEF_PINS   = 8;
    localparam int WK_DEF_STAGES = 2;

    typedef enum logic [1:0] {
        WK_IDLE     = 2'd0,
        WK_WAIT_LOW = 2'd1,
        WK_ARMED    = 2'd2,
        WK_SPENT    = 2'd3
    } wk_state_e;

    typedef struct packed {
        wk_state_e state;
        logic      fire;
    } wk_step_t;

    function automatic wk_step_t wk_next(input wk_state_e cur,
                                         input logic suspended,
                                         input logic susp_level,
                                         input logic multi_en,
                                         input logic hit);
        wk_step_t r;
        r.state = cur;
        r.fire  = 1'b0;
        if (!suspended) begin
            r.state = WK_IDLE;
        end else begin
            unique case (cur)
                WK_IDLE:     r.state = WK_WAIT_LOW;
                WK_WAIT_LOW: begin
                    if (!susp_level) begin
                        if (multi_en) begin
                            r.state = WK_ARMED;
                        end else begin
                            r.fire  = 1'b1;
                            r.state = WK_SPENT;
                        end
                    end
                end
                WK_ARMED: begin
                    if (hit) begin
                        r.fire  = 1'b1;
                        r.state = WK_SPENT;
                    end
                end
                WK_SPENT:    r.state = WK_SPENT;
                default:     r.state = WK_IDLE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = wk_pkg::WK_DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wk_edge_bank.sv
module wk_edge_bank #(
    parameter int NUM_PINS = wk_pkg::WK_DEF_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] level,
    output logic [NUM_PINS-1:0] rise
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic prev;
        always_ff @(posedge clk) begin
            if (rst) prev <= 1'b0;
            else     prev <= level[i];
        end
        assign rise[i] = level[i] & ~prev;
    end
endmodule

// File: rtl/wk_arm_fsm.sv
module wk_arm_fsm (
    input  logic clk,
    input  logic rst,
    input  logic suspended,
    input  logic susp_level,
    input  logic multi_en,
    input  logic hit,
    output logic fire,
    output logic armed
);
    import wk_pkg::*;

    wk_state_e state_q;
    wk_step_t  step;

    always_comb begin
        step = wk_next(state_q, suspended, susp_level, multi_en, hit);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WK_IDLE;
        else     state_q <= step.state;
    end

    assign fire  = step.fire;
    assign armed = (state_q == WK_ARMED);
endmodule

// File: rtl/multipin_wake_detector.sv
module multipin_wake_detector #(
    parameter int NUM_PINS    = wk_pkg::WK_DEF_PINS,
    parameter int SYNC_STAGES = wk_pkg::WK_DEF_STAGES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] wake_pins,
    input  logic [NUM_PINS-1:0] pin_mask,
    input  logic                multi_en,
    input  logic                suspend_pin,
    input  logic                suspended,
    output logic                wake_pulse,
    output logic                mask_empty
);
    localparam int SYNC_W = NUM_PINS + 1;

    logic [SYNC_W-1:0]   sync_q;
    logic [NUM_PINS-1:0] pin_level;
    logic                susp_level;
    logic [NUM_PINS-1:0] rise_vec;
    logic                hit;
    logic                fire;
    logic                armed;

    // R1: one synchroniser chain shared by the pins and the suspend pin
    wk_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({suspend_pin, wake_pins}),
        .q   (sync_q)
    );

    assign pin_level  = sync_q[NUM_PINS-1:0];
    assign susp_level = sync_q[NUM_PINS];

    wk_edge_bank #(.NUM_PINS(NUM_PINS)) u_edges (
        .clk   (clk),
        .rst   (rst),
        .level (pin_level),
        .rise  (rise_vec)
    );

    assign hit = |(rise_vec & pin_mask);

    wk_arm_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .suspended  (suspended),
        .susp_level (susp_level),
        .multi_en   (multi_en),
        .hit        (hit),
        .fire       (fire),
        .armed      (armed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_pulse <= 1'b0;
            mask_empty <= 1'b0;
        end else begin
            wake_pulse <= fire;
            mask_empty <= multi_en & ~|pin_mask;
        end
    end
endmodule

// File: rtl/multipin_wake_detector_chk.sv
module multipin_wake_detector_chk #(
    parameter int NUM_PINS = wk_pkg::WK_DEF_PINS
) (
    input logic                clk,
    input logic                rst,
    input logic                suspended,
    input logic                multi_en,
    input logic [NUM_PINS-1:0] pin_mask,
    input logic [NUM_PINS-1:0] rise_vec,
    input logic                armed,
    input logic                wake_pulse,
    input logic                mask_empty
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    a_r8_disarm: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> !armed);

    a_r9_needs_suspend: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(suspended));

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (armed && ((rise_vec & pin_mask) == '0)) |=> !wake_pulse);

    a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
        (multi_en && pin_mask == '0) |=> mask_empty);

    a_r10_flag_clr: assert property (@(posedge clk) disable iff (rst)
        (!multi_en || pin_mask != '0) |=> !mask_empty);
endmodule

bind multipin_wake_detector multipin_wake_detector_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .suspended  (suspended),
    .multi_en   (multi_en),
    .pin_mask   (pin_mask),
    .rise_vec   (rise_vec),
    .armed      (armed),
    .wake_pulse (wake_pulse),
    .mask_empty (mask_empty)
);

// File: tb/multipin_wake_detector_tb.sv
module multipin_wake_detector_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wake_pins = '0;
    logic [7:0] pin_mask = 8'hFF;
    logic       multi_en = 1'b0;
    logic       suspend_pin = 1'b0;
    logic       suspended = 1'b0;
    logic       wake_pulse;
    logic       mask_empty;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    multipin_wake_detector u_dut (
        .clk         (clk),
        .rst         (rst),
        .wake_pins   (wake_pins),
        .pin_mask    (pin_mask),
        .multi_en    (multi_en),
        .suspend_pin (suspend_pin),
        .suspended   (suspended),
        .wake_pulse  (wake_pulse),
        .mask_empty  (mask_empty)
    );

    typedef struct packed {
        logic [7:0] mask;
        logic       multi;
        logic [7:0] pre;
        logic [7:0] post;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'hFF, 1'b1, 8'h00, 8'h01, 1'b1, 4'd1},  // R1 pin 0 wakes
        '{8'h0F, 1'b1, 8'h00, 8'h10, 1'b0, 4'd2},  // R2 pin 4 outside 0x0F
        '{8'h0F, 1'b1, 8'h00, 8'h08, 1'b1, 4'd2},  // R2 pin 3 inside 0x0F
        '{8'h0F, 1'b1, 8'h00, 8'h80, 1'b0, 4'd6},  // R6 masked pin 7
        '{8'h80, 1'b1, 8'h00, 8'h80, 1'b1, 4'd2},  // R2 only pin 7
        '{8'hFF, 1'b1, 8'h04, 8'h04, 1'b0, 4'd7},  // R7 held high at entry
        '{8'hFF, 1'b0, 8'h00, 8'h00, 1'b1, 4'd4},  // R4 suspend low wakes
        '{8'hFF, 1'b1, 8'h00, 8'h00, 1'b0, 4'd5},  // R5 suspend low only
        '{8'h00, 1'b1, 8'h00, 8'hFF, 1'b0, 4'd6},  // R6 empty mask
        '{8'h01, 1'b1, 8'h00, 8'hFF, 1'b1, 4'd8}   // R8 many edges, one pulse
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_wakes(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (wake_pulse) c++;
        end
    endtask

    task automatic enter(input logic [7:0] pre);
        wake_pins = pre;
        tick(4);
        suspend_pin = 1'b1;
        tick(3);
        suspended = 1'b1;
        tick(4);
    endtask

    task automatic leave();
        suspended = 1'b0;
        suspend_pin = 1'b0;
        wake_pins = '0;
        tick(4);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c1;
        int c2;
        // R11: reset state, with an empty-mask configuration held during reset
        multi_en = 1'b1;
        pin_mask = 8'h00;
        tick(3);
        check(wake_pulse == 1'b0, "R11", wake_pulse, 0);
        check(mask_empty == 1'b0, "R11", mask_empty, 0);
        rst = 1'b0;
        tick(1);
        check(mask_empty == 1'b1, "R10", mask_empty, 1);   // R10 set
        pin_mask = 8'h01;
        tick(1);
        check(mask_empty == 1'b0, "R10", mask_empty, 0);
        multi_en = 1'b0;
        pin_mask = 8'h00;
        tick(1);
        check(mask_empty == 1'b0, "R10", mask_empty, 0);

        // table of suspend episodes
        for (int i = 0; i < NV; i++) begin
            pin_mask = VECS[i].mask;
            multi_en = VECS[i].multi;
            enter(VECS[i].pre);
            suspend_pin = 1'b0;
            count_wakes(6, c1);
            wake_pins = VECS[i].post;
            count_wakes(8, c2);
            checks++;
            if (c1 + c2 != int'(VECS[i].exp)) begin
                errors++;
                $display("FAIL R%0d row %0d: actual %0d expected %0d",
                         VECS[i].req, i, c1 + c2, VECS[i].exp);
            end
            leave();
        end

        // R4: exact latency of suspend-pin wake with multi-pin mode off
        multi_en = 1'b0;
        pin_mask = 8'hFF;
        enter(8'h00);
        suspend_pin = 1'b0;
        tick(2);
        check(wake_pulse == 1'b0, "R4", wake_pulse, 0);
        tick(1);
        check(wake_pulse == 1'b1, "R4", wake_pulse, 1);
        leave();

        // R1: exact pin latency, then R8 single cycle and disarm
        multi_en = 1'b1;
        enter(8'h00);
        suspend_pin = 1'b0;
        tick(5);
        wake_pins = 8'h01;
        tick(2);
        check(wake_pulse == 1'b0, "R1", wake_pulse, 0);
        tick(1);
        check(wake_pulse == 1'b1, "R1", wake_pulse, 1);
        tick(1);
        check(wake_pulse == 1'b0, "R8", wake_pulse, 0);
        wake_pins = 8'h03;
        count_wakes(6, c1);
        check(c1 == 0, "R8", c1, 0);
        leave();

        // R3: edge while suspend still high is ignored
        enter(8'h00);
        wake_pins = 8'h01;
        count_wakes(6, c1);
        check(c1 == 0, "R3", c1, 0);
        suspend_pin = 1'b0;
        count_wakes(6, c1);
        check(c1 == 0, "R3", c1, 0);
        wake_pins = 8'h00;
        tick(4);
        wake_pins = 8'h01;
        count_wakes(6, c1);
        check(c1 == 1, "R3", c1, 1);
        leave();

        // R9: not suspended, suspend pin pulses and pins toggle
        multi_en = 1'b0;
        suspend_pin = 1'b1;
        tick(4);
        suspend_pin = 1'b0;
        wake_pins = 8'hFF;
        count_wakes(8, c1);
        check(c1 == 0, "R9", c1, 0);
        leave();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule